// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into a baud-rate tick whose average rate can be set far more finely than one integer divider allows. It works in two stages. An integer prescaler divides the clock by `scale + 1`. On each prescaler pulse, a 17-bit phase accumulator adds `step`, and the carry out of its top bit becomes the tick. The average tick rate is therefore `f_clk / (scale + 1) * step / 2^17`.

Both settings live in one 32-bit configuration register. Software writes it through a plain write port: a one-cycle strobe with a byte offset and a data word. The port has no handshake and no back-pressure. Every strobe is taken in the cycle it is presented, and the block never stalls the writer. The register value is always visible on a readback output. A write that hits the register also restarts the prescaler and the accumulator from zero, so a new rate begins from a known phase.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 (scale 0, step 0) and `tick` stays low until the register is written.
- R2: A write with `wr_en` high and `wr_addr` equal to 0x08 loads scale from `wr_data[27:16]` and step from `wr_data[15:0]`. From the next cycle, `cfg_rdata` reads `{4'b0, scale, step}`, so bits 31:28 always read 0.
- R3: A write at any other offset leaves `cfg_rdata` and the tick schedule untouched.
- R4: With scale 0, the accumulator advances on every clock cycle, so ticks follow `step / 2^17` per cycle.
- R5: Count clock edges from the write edge, so that the write edge is edge 0. Tick number m is high in the cycle after edge `k = m*(scale+1)` exactly when `floor(m*step/2^17) > floor((m-1)*step/2^17)`. The tick is low in every other cycle.
- R6: The tick is high for a single cycle at a time.
- R7: With step 0, no tick is ever produced.
- R8: A register write clears the prescaler count, the accumulator and any tick due on the write edge. The new schedule of R5 starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration register value |
| tick | output | 1 | One-cycle baud tick |

## Verification
The two functions that can land on the same clock edge are a register write and an accumulator carry that would raise the tick. The bench provokes this by timing a rewrite so that its write edge is the very edge on which a tick is due. It then requires that no tick appears on that edge and that the following ticks follow the new schedule counted from the write. A write to a foreign offset is also placed in the middle of a running schedule, and the ticks must continue on the old timetable.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_SCALE_W   = 12;
  localparam int unsigned DEF_STEP_W    = 16;
  localparam int unsigned DEF_SCALE_LSB = 16;
  localparam logic [DEF_ADDR_W-1:0] DEF_CFG_OFS = 8'h08;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int unsigned ADDR_W    = baud_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] CFG_OFS = baud_pkg::DEF_CFG_OFS,
  parameter int unsigned SCALE_W   = baud_pkg::DEF_SCALE_W,
  parameter int unsigned STEP_W    = baud_pkg::DEF_STEP_W,
  parameter int unsigned SCALE_LSB = baud_pkg::DEF_SCALE_LSB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [baud_pkg::REG_W-1:0] wr_data,
  output logic [SCALE_W-1:0]         scale,
  output logic [STEP_W-1:0]          step,
  output logic                       wr_hit,
  output logic [baud_pkg::REG_W-1:0] rdata
);
  logic unused_wr_bits;

  assign wr_hit = wr_en && (wr_addr == CFG_OFS);
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0;
      step  <= '0;
    end else if (wr_hit) begin
      scale <= wr_data[SCALE_LSB +: SCALE_W];
      step  <= wr_data[STEP_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SCALE_LSB +: SCALE_W] = scale;
    rdata[STEP_W-1:0]           = step;
  end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned SCALE_W = baud_pkg::DEF_SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [SCALE_W-1:0] scale,
  output logic               pulse
);
  logic [SCALE_W-1:0] cnt;

  assign pulse = (cnt == scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || pulse)   cnt <= '0;
    else                     cnt <= cnt + SCALE_W'(1);
  end
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned STEP_W = baud_pkg::DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic              carry
);
  localparam int unsigned ACC_W = STEP_W + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {2'b00, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      carry <= 1'b0;
    end else if (clr) begin
      acc   <= '0;
      carry <= 1'b0;
    end else if (adv) begin
      acc   <= sum[ACC_W-1:0];
      carry <= sum[ACC_W];
    end else begin
      carry <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned ADDR_W    = baud_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] CFG_OFS = baud_pkg::DEF_CFG_OFS,
  parameter int unsigned SCALE_W   = baud_pkg::DEF_SCALE_W,
  parameter int unsigned STEP_W    = baud_pkg::DEF_STEP_W,
  parameter int unsigned SCALE_LSB = baud_pkg::DEF_SCALE_LSB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [baud_pkg::REG_W-1:0] wr_data,
  output logic [baud_pkg::REG_W-1:0] cfg_rdata,
  output logic                       tick
);
  logic [SCALE_W-1:0] scale;
  logic [STEP_W-1:0]  step;
  logic               wr_hit;
  logic               pulse;

  baud_cfg_reg #(
    .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .SCALE_W(SCALE_W),
    .STEP_W(STEP_W), .SCALE_LSB(SCALE_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .scale(scale), .step(step),
    .wr_hit(wr_hit), .rdata(cfg_rdata)
  );

  baud_prescale #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_hit), .scale(scale), .pulse(pulse)
  );

  baud_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(wr_hit), .adv(pulse),
    .step(step), .carry(tick)
  );
endmodule

module baud_tick_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_OFS = 8'h08,
  parameter int unsigned SCALE_W   = 12,
  parameter int unsigned STEP_W    = 16,
  parameter int unsigned SCALE_LSB = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [31:0]        wr_data,
  input logic               wr_hit,
  input logic               pulse,
  input logic [SCALE_W-1:0] scale,
  input logic [31:0]        cfg_rdata,
  input logic               tick
);
  a_r2_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cfg_rdata[SCALE_LSB +: SCALE_W] == $past(wr_data[SCALE_LSB +: SCALE_W]))
            && (cfg_rdata[STEP_W-1:0] == $past(wr_data[STEP_W-1:0])));

  a_r3_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CFG_OFS) |=> $stable(cfg_rdata));

  a_r4_scale0_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == '0) |-> pulse);

  a_r5_tick_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(pulse));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r7_step0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[STEP_W-1:0] == '0 && !wr_hit) |=> !tick);

  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !tick);
endmodule

bind baud_tick_gen baud_tick_chk #(
  .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .SCALE_W(SCALE_W),
  .STEP_W(STEP_W), .SCALE_LSB(SCALE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_hit(wr_hit), .pulse(pulse), .scale(scale),
  .cfg_rdata(cfg_rdata), .tick(tick)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] cfg_rdata;
  logic        tick;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_rdata(cfg_rdata), .tick(tick)
  );

  always #2 clk = ~clk;

  longint unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint unsigned exp_q[$];
  longint unsigned w_cyc = 0;
  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  bit    mon_on = 1'b0;
  bit    prev_tick = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every observed tick.
  always @(negedge clk) begin
    longint unsigned e;
    if (mon_on && rst_n) begin
      if (tick) begin
        chk(!prev_tick, "R6", "tick high two cycles", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, tag, "unexpected tick at cycle", longint'(cyc), 0);
        end else begin
          e = exp_q.pop_front();
          chk(e == cyc, tag, "tick cycle", longint'(cyc), longint'(e));
        end
      end
      prev_tick = tick;
    end
  end

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // Driver: writes a rate and pushes the expected tick cycles (R5).
  task automatic start_rate(input logic [11:0] s, input logic [15:0] st,
                            input longint unsigned len, input string t,
                            input logic [3:0] junk);
    longint unsigned per;
    write_reg(8'h08, {junk, s, st});
    w_cyc = cyc;
    exp_q.delete();
    tag = t;
    per = longint'(s) + 1;
    for (longint unsigned m = 1; m * per <= len; m++) begin
      if (((m * st) >> 17) != (((m - 1) * st) >> 17))
        exp_q.push_back(w_cyc + m * per);
    end
    chk(cfg_rdata == {4'h0, s, st}, "R2", "readback", cfg_rdata, {4'h0, s, st});
  endtask

  task automatic run_out(input longint unsigned len);
    wait (cyc >= w_cyc + len + 1);
    @(negedge clk);
    chk(exp_q.size() == 0, tag, "ticks missing at window end", exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1", "reset readback", cfg_rdata, 0);
    chk(tick == 1'b0, "R1", "reset tick", tick, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tag = "R1";
    repeat (50) @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1", "idle readback", cfg_rdata, 0);

    // R4: scale 0, step 2^15 -> one tick every 4 cycles
    start_rate(12'd0, 16'h8000, 200, "R4", 4'hF);
    run_out(200);

    // R4/R5: scale 0, fractional spacing 5/5/6
    start_rate(12'd0, 16'h6000, 300, "R4", 4'h5);
    run_out(300);

    // R5: prescaled rates
    start_rate(12'd2, 16'h5555, 900, "R5", 4'hA);
    run_out(900);
    start_rate(12'd99, 16'h4000, 4000, "R5", 4'h0);
    run_out(4000);
    start_rate(12'd6, 16'hFFFF, 600, "R5", 4'h3);
    run_out(600);

    // R2: upper bits masked on readback
    write_reg(8'h08, 32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0FFF_FFFF, "R2", "upper bits zero", cfg_rdata, 32'h0FFF_FFFF);

    // R7: step 0 silent even with scale 0
    start_rate(12'd0, 16'h0000, 500, "R7", 4'h0);
    run_out(500);
    start_rate(12'd3, 16'h0000, 500, "R7", 4'h0);
    run_out(500);

    // R3: foreign offsets mid-schedule
    start_rate(12'd1, 16'h6000, 400, "R3", 4'h0);
    wait (cyc == w_cyc + 10);
    write_reg(8'h04, 32'h0000_0000);
    chk(cfg_rdata == {4'h0, 12'd1, 16'h6000}, "R3", "readback after 0x04", cfg_rdata, {4'h0, 12'd1, 16'h6000});
    write_reg(8'h0C, 32'h0123_4567);
    chk(cfg_rdata == {4'h0, 12'd1, 16'h6000}, "R3", "readback after 0x0C", cfg_rdata, {4'h0, 12'd1, 16'h6000});
    run_out(400);

    // R8: rewrite lands on the edge where a tick is due (k=4)
    start_rate(12'd0, 16'h8000, 100, "R8", 4'h0);
    wait (cyc == w_cyc + 3);
    start_rate(12'd0, 16'h8000, 200, "R8", 4'h0);
    @(negedge clk);
    chk(tick == 1'b0, "R8", "tick suppressed on write edge", tick, 0);
    run_out(200);

    // R8: rewrite to a new rate mid-run restarts phase
    start_rate(12'd4, 16'hC000, 300, "R8", 4'h0);
    wait (cyc == w_cyc + 7);
    start_rate(12'd2, 16'h3000, 600, "R8", 4'h0);
    run_out(600);

    summary();
  end
endmodule